// File: doc/BRIEF.md
# Line-bounded instruction fetch requester

This block turns a fetch grant for one wavefront slot into a memory read request. The grant carries the slot number, the program counter, how many instructions are already buffered for that slot, and the base byte address of the slot's code. Instruction slots are 8 bytes wide. The block skips past the instructions already held, so the byte address it forms is `base + (pc + occupancy) * 8`. The request length is cut at the end of the cache line that holds that address, so no request ever spans two lines. A line-aligned address asks for a whole line. Address translation is treated as identity, so the computed address goes out unchanged.

Requests leave on a valid/ready port and carry the slot number, so the response can be routed back to its slot. The grant side uses valid/ready as well. `grant_ready` is high whenever the retry queue has room, and a grant is taken on any cycle where `grant_valid` and `grant_ready` are both high. A refusal is a cycle in which `req_valid` is high and `req_ready` is low. A refusal puts the port into a stalled state and keeps the refused request in a retry queue.

While the port is stalled, nothing is offered, and every accepted grant is appended to the queue. A one-cycle `retry_go` pulse clears the stall. The queue then drains oldest first. New grants go straight to the port only once the queue is empty. The queue depth equals the number of slots, since each slot has at most one fetch in flight.

Top module: `ifetch_line_req`

## Requirements
- R1: The request address equals `grant_base + (grant_pc + grant_occ) * 8`, modulo 2^ADDR_W.
- R2: When the request address is a multiple of LINE_BYTES, `req_size` equals LINE_BYTES.
- R3: When the address is not line-aligned, `req_size` equals LINE_BYTES minus (address mod LINE_BYTES), so address plus size lands exactly on the next line boundary.
- R4: When the port is not stalled and the queue is empty, a grant is offered on the request port in the same cycle, with `req_slot` equal to `grant_slot`.
- R5: A refused request sets the stalled state on the next edge. That request is later offered again with the same address, size and slot, including when the refusal hits the head of the queue during a drain.
- R6: While stalled, `req_valid` is low and accepted grants are queued rather than offered.
- R7: After a `retry_go` pulse, queued requests are offered in arrival order, and grants that arrive during the drain are queued behind them.
- R8: `grant_ready` is low when the queue holds SLOTS entries. A grant presented then is not taken.
- R9: After reset, `req_valid` is low, `grant_ready` is high and the port is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_valid | input | 1 | A fetch grant is presented |
| grant_ready | output | 1 | Block can take the grant (queue not full) |
| grant_slot | input | SLOT_W | Wavefront slot of the grant |
| grant_pc | input | ADDR_W | Program counter in instruction units |
| grant_occ | input | OCC_W | Instructions already buffered for the slot |
| grant_base | input | ADDR_W | Byte base address of the slot's code |
| retry_go | input | 1 | Pulse that clears the stalled state |
| req_valid | output | 1 | Fetch request offered |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | ADDR_W | Fetch byte address |
| req_size | output | SIZE_W | Fetch length in bytes, 1..LINE_BYTES |
| req_slot | output | SLOT_W | Slot the response belongs to |

## Verification
The bench builds the block with SLOTS=4 and LINE_BYTES=32. Four slots let the queue reach its full depth within a few cycles, so the full-queue refusal of a grant and a complete drain can both be seen at the ports. A 32-byte line holds only four instruction slots, so each in-line offset (0, 8, 16, 24) and a base that is not 8-byte aligned appear in a short vector table. One of those vectors sits at the top of the address space.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  // each instruction slot occupies 8 bytes
  localparam int unsigned INST_SHIFT = 3;

  // where the offered request comes from
  typedef enum logic {
    SRC_LIVE  = 1'b0,
    SRC_QUEUE = 1'b1
  } src_e;
endpackage

// File: rtl/ifr_addr_calc.sv
module ifr_addr_calc #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OCC_W      = 4,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned LB_W      = $clog2(LINE_BYTES),
  localparam int unsigned SIZE_W    = LB_W + 1
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OCC_W-1:0]  occ,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic [SIZE_W-1:0] size
);
  import ifr_pkg::*;

  logic [ADDR_W-1:0] slot_idx;
  logic [LB_W-1:0]   line_off;

  always_comb begin
    slot_idx = pc + ADDR_W'(occ);
    addr     = base + (slot_idx << INST_SHIFT);
    line_off = addr[LB_W-1:0];
    if (line_off == '0) size = SIZE_W'(LINE_BYTES);
    else                size = SIZE_W'(LINE_BYTES) - {1'b0, line_off};
  end
endmodule

// File: rtl/ifr_retry_fifo.sv
module ifr_retry_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: the requester must never push into a full queue
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7: draining only happens while entries exist
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ifetch_line_req.sv
module ifetch_line_req #(
  parameter int unsigned SLOTS      = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OCC_W      = 4,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned LB_W      = $clog2(LINE_BYTES),
  localparam int unsigned SIZE_W    = LB_W + 1,
  localparam int unsigned PKT_W     = SLOT_W + ADDR_W + SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  output logic              grant_ready,
  input  logic [SLOT_W-1:0] grant_slot,
  input  logic [ADDR_W-1:0] grant_pc,
  input  logic [OCC_W-1:0]  grant_occ,
  input  logic [ADDR_W-1:0] grant_base,
  input  logic              retry_go,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SIZE_W-1:0] req_size,
  output logic [SLOT_W-1:0] req_slot
);
  import ifr_pkg::*;

  logic [ADDR_W-1:0] live_addr;
  logic [SIZE_W-1:0] live_size;
  logic [PKT_W-1:0]  live_pkt, head_pkt, out_pkt;
  logic              q_empty, q_full, q_push, q_pop;
  logic              stalled, grant_fire, refused;
  src_e              src;

  ifr_addr_calc #(
    .ADDR_W(ADDR_W), .OCC_W(OCC_W), .LINE_BYTES(LINE_BYTES)
  ) u_calc (
    .pc(grant_pc), .occ(grant_occ), .base(grant_base),
    .addr(live_addr), .size(live_size)
  );

  assign live_pkt = {grant_slot, live_addr, live_size};

  ifr_retry_fifo #(.DEPTH(SLOTS), .DATA_W(PKT_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_data(live_pkt),
    .pop(q_pop), .head(head_pkt),
    .empty(q_empty), .full(q_full)
  );

  always_comb begin
    src         = q_empty ? SRC_LIVE : SRC_QUEUE;
    grant_ready = !q_full;
    grant_fire  = grant_valid && grant_ready;
    if (stalled)               req_valid = 1'b0;
    else if (src == SRC_LIVE)  req_valid = grant_valid;
    else                       req_valid = 1'b1;
    out_pkt  = (src == SRC_LIVE) ? live_pkt : head_pkt;
    refused  = req_valid && !req_ready;
    q_pop    = !stalled && (src == SRC_QUEUE) && req_ready;
    // a grant bypasses the queue only if it went out directly this cycle
    q_push   = grant_fire && (stalled || (src == SRC_QUEUE) || !req_ready);
  end

  assign {req_slot, req_addr, req_size} = out_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n)        stalled <= 1'b0;
    else if (refused)  stalled <= 1'b1;
    else if (retry_go) stalled <= 1'b0;
  end

  // R5: a refusal always leaves the port stalled
  p_refuse_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !req_valid);

  // R3: the request ends exactly on a line boundary
  p_line_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (({1'b0, req_addr[LB_W-1:0]} + req_size) == SIZE_W'(LINE_BYTES)));

  // R9: idle after reset, nothing offered without a grant or queued entry
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !grant_valid) |-> !req_valid);
endmodule

// File: tb/sim_ifetch_line_req.sv
`timescale 1ns/1ps
module sim_ifetch_line_req;
  localparam int unsigned SLOTS = 4;
  localparam int unsigned AW    = 32;
  localparam int unsigned OW    = 4;
  localparam int unsigned LINE  = 32;
  localparam int unsigned SW    = 2;
  localparam int unsigned ZW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grant_valid = 1'b0, grant_ready;
  logic [SW-1:0] grant_slot = '0;
  logic [AW-1:0] grant_pc = '0, grant_base = '0;
  logic [OW-1:0] grant_occ = '0;
  logic          retry_go = 1'b0;
  logic          req_valid, req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic [ZW-1:0] req_size;
  logic [SW-1:0] req_slot;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ifetch_line_req #(.SLOTS(SLOTS), .ADDR_W(AW), .OCC_W(OW), .LINE_BYTES(LINE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_slot(grant_slot), .grant_pc(grant_pc), .grant_occ(grant_occ),
    .grant_base(grant_base), .retry_go(retry_go),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_slot(req_slot)
  );

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] pc;
    logic [OW-1:0] occ;
    logic [SW-1:0] slot;
    logic [AW-1:0] addr;
    logic [ZW-1:0] size;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0000_1000, 32'd0,  4'd0, 2'd0, 32'h0000_1000, 6'd32},
    '{32'h0000_1000, 32'd1,  4'd0, 2'd1, 32'h0000_1008, 6'd24},
    '{32'h0000_1000, 32'd2,  4'd1, 2'd2, 32'h0000_1018, 6'd8},
    '{32'h0000_1004, 32'd3,  4'd1, 2'd3, 32'h0000_1024, 6'd28},
    '{32'h0000_2000, 32'd0,  4'd4, 2'd1, 32'h0000_2020, 6'd32},
    '{32'hFFFF_FFF8, 32'd0,  4'd0, 2'd2, 32'hFFFF_FFF8, 6'd8},
    '{32'h0000_3010, 32'd5,  4'd2, 2'd3, 32'h0000_3048, 6'd24},
    '{32'h0000_0000, 32'd16, 4'd3, 2'd0, 32'h0000_0098, 6'd8}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic grant(input logic v, input logic [SW-1:0] s, input logic [AW-1:0] b,
                       input logic [AW-1:0] p, input logic [OW-1:0] o);
    grant_valid = v; grant_slot = s; grant_base = b; grant_pc = p; grant_occ = o;
  endtask

  task automatic expect_req(input string req, input logic [AW-1:0] a,
                            input logic [ZW-1:0] z, input logic [SW-1:0] s);
    chk(req_valid === 1'b1, req, "req_valid", 64'(req_valid), 64'd1);
    chk(req_addr === a, req, "req_addr", 64'(req_addr), 64'(a));
    chk(req_size === z, req, "req_size", 64'(req_size), 64'(z));
    chk(req_slot === s, req, "req_slot", 64'(req_slot), 64'(s));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(req_valid === 1'b0, "R9", "req_valid in reset", 64'(req_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_valid === 1'b0, "R9", "req_valid after reset", 64'(req_valid), 64'd0);
    chk(grant_ready === 1'b1, "R9", "grant_ready after reset", 64'(grant_ready), 64'd1);

    // R1 R2 R3 R4: vector walk with the port always ready
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      grant(1'b1, VEC[i].slot, VEC[i].base, VEC[i].pc, VEC[i].occ);
      #1;
      expect_req((VEC[i].size == 6'd32) ? "R2" : "R3", VEC[i].addr, VEC[i].size, VEC[i].slot);
      chk(req_addr === VEC[i].addr, "R1", "address formula", 64'(req_addr), 64'(VEC[i].addr));
      chk(req_slot === VEC[i].slot, "R4", "direct slot", 64'(req_slot), 64'(VEC[i].slot));
    end
    @(negedge clk); grant(1'b0, 0, 0, 0, 0); #1;
    chk(req_valid === 1'b0, "R4", "idle after vectors", 64'(req_valid), 64'd0);

    // R5 R6 R7: refusal, queuing while stalled, ordered drain
    @(negedge clk); req_ready = 1'b0; grant(1'b1, 2'd1, 32'h4000, 32'd0, 4'd0); #1;
    expect_req("R4", 32'h4000, 6'd32, 2'd1);
    @(negedge clk); req_ready = 1'b1; grant(1'b1, 2'd2, 32'h4000, 32'd1, 4'd0); #1;
    chk(req_valid === 1'b0, "R6", "stalled offers nothing", 64'(req_valid), 64'd0);
    chk(grant_ready === 1'b1, "R6", "grant taken while stalled", 64'(grant_ready), 64'd1);
    @(negedge clk); grant(1'b1, 2'd3, 32'h4000, 32'd2, 4'd2); #1;
    chk(req_valid === 1'b0, "R6", "still stalled", 64'(req_valid), 64'd0);
    @(negedge clk); grant(1'b0, 0, 0, 0, 0); retry_go = 1'b1; #1;
    chk(req_valid === 1'b0, "R6", "stalled during retry pulse", 64'(req_valid), 64'd0);
    @(negedge clk); retry_go = 1'b0; grant(1'b1, 2'd0, 32'h4000, 32'd7, 4'd0); #1;
    expect_req("R5", 32'h4000, 6'd32, 2'd1);
    @(negedge clk); grant(1'b0, 0, 0, 0, 0); req_ready = 1'b0; #1;
    expect_req("R7", 32'h4008, 6'd24, 2'd2);
    @(negedge clk); req_ready = 1'b1; #1;
    chk(req_valid === 1'b0, "R5", "head refusal re-stalls", 64'(req_valid), 64'd0);
    retry_go = 1'b1;
    @(negedge clk); retry_go = 1'b0; #1;
    expect_req("R5", 32'h4008, 6'd24, 2'd2);
    @(negedge clk); #1;
    expect_req("R7", 32'h4020, 6'd32, 2'd3);
    @(negedge clk); #1;
    expect_req("R7", 32'h4038, 6'd8, 2'd0);
    @(negedge clk); #1;
    chk(req_valid === 1'b0, "R7", "queue drained", 64'(req_valid), 64'd0);

    // R8: fill the queue while stalled
    req_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); grant(1'b1, SW'(k), 32'h5000, 32'(k), 4'd0); #1;
      chk(grant_ready === 1'b1, "R8", "room before full", 64'(grant_ready), 64'd1);
    end
    @(negedge clk); grant(1'b1, 2'd3, 32'h6000, 32'd0, 4'd0); #1;
    chk(grant_ready === 1'b0, "R8", "full queue blocks grant", 64'(grant_ready), 64'd0);
    chk(req_valid === 1'b0, "R6", "full and stalled", 64'(req_valid), 64'd0);
    @(negedge clk); grant(1'b0, 0, 0, 0, 0); retry_go = 1'b1;
    @(negedge clk); retry_go = 1'b0; req_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      expect_req("R7", 32'h5000 + 32'(8 * k), 6'(32 - 8 * k), SW'(k));
      @(negedge clk);
    end
    #1;
    chk(req_valid === 1'b0, "R8", "blocked grant never queued", 64'(req_valid), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule